// File: doc/BRIEF.md
# System Exception Control Registers

This block is a small memory-mapped register file that owns the pending and active state of three fixed system exceptions: the non-maskable interrupt (number 2), a software-requested context-switch exception (number 14) and a periodic timer exception (number 15). It also holds the two-bit handler priorities for the supervisor call (number 11), the context-switch exception and the timer exception. From the pending flags and those priorities it derives the number of the exception that should be taken next.

Software reaches the block through a synchronous read/write port addressed by a word offset. Each pendable exception has a set bit and, except for the NMI, a clear bit in the control/state word. A keyed word raises a sticky system reset request and can wipe the active exception number. The core side drives a timer tick input, a handler-entry acknowledge carrying an exception number, and a level that tells the block that some external interrupt is pending.

Top module: `sysexc_ctrl`

## Requirements
- R1: After a synchronous reset, all three pending flags, `pend_num`, `sys_reset_req` and the active number are 0, and every readable word returns 0.
- R2: A write to word offset 0x341 (the control/state word) with bit 31 set makes the NMI pending, with bit 28 set makes the context-switch exception pending, and with bit 26 set makes the timer exception pending. A `tick_req` pulse also makes the timer exception pending. The pending outputs change in the cycle after the write.
- R3: In the control/state word, bit 27 clears the context-switch pending flag and bit 25 clears the timer pending flag. When a set and its matching clear arrive in the same cycle, the set wins. A `tick_req` pulse together with a timer clear write leaves the timer exception pending.
- R4: An `ack_valid` pulse with `ack_num` equal to 2, 14 or 15 clears that exception's pending flag, unless a set for the same exception arrives in the same cycle. Every `ack_valid` pulse loads `ack_num` into the active number, and 0 marks thread mode.
- R5: `pend_num` is 2 while the NMI is pending. Otherwise it is the pending exception (14 or 15) with the smaller priority value, with 14 taken on a tie, or 0 when nothing is pending. It is computed from the registered flags.
- R6: A read of the control/state word returns the active number in bits 5:0 and `pend_num` in bits 17:12. Bit 22 is `ext_irq_pend` OR the context-switch flag OR the timer flag. Bits 26, 28 and 31 return the timer, context-switch and NMI flags. All other bits read 0. Writes to bits 5:0, 17:12, 22 and 23 have no effect.
- R7: Word 0x347 holds the supervisor-call priority in bits 31:30. Word 0x348 holds the context-switch priority in bits 23:22 and the timer priority in bits 31:30. All other bits of both words read 0.
- R8: A write to word 0x343 (the keyed reset word) is accepted only when bits 31:16 equal 0x05FA. An accepted write with bit 2 set raises `sys_reset_req`, which stays high until reset. The word always reads 0.
- R9: An accepted write to the keyed reset word with bit 1 set clears the active number to 0, overriding a handler-entry acknowledge in the same cycle. A write with a wrong key leaves the active number unchanged.
- R10: `bus_rdata` carries the word addressed in the cycle after `bus_rd` and is 0 in any other cycle. Offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| tick_req | input | 1 | Timer tick, makes the timer exception pending |
| ack_valid | input | 1 | Handler-entry acknowledge pulse |
| ack_num | input | 6 | Exception number being entered (0 = thread mode) |
| ext_irq_pend | input | 1 | Some external interrupt is pending |
| pend_nmi | output | 1 | NMI pending flag |
| pend_csw | output | 1 | Context-switch exception pending flag |
| pend_tmr | output | 1 | Timer exception pending flag |
| pend_num | output | 6 | Number of the exception to take next, 0 when none |
| sys_reset_req | output | 1 | Sticky system reset request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never raised together and that `ack_num`, when acknowledged, names either thread mode or one of the exceptions the block knows about. The stimulus holds to these assumptions. Every access is issued alone from a task, and acknowledges use only 0, 2, 14 and 15. The only overlaps the bench creates on purpose are a set write together with an acknowledge, a tick together with a clear write, and an acknowledge together with a keyed clear. These are the overlaps whose outcome the requirements define.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 10;
    localparam int EXC_W    = 6;
    localparam int PRIO_W   = 2;
    localparam int NUM_PEND = 3;
    localparam int KEY_W    = 16;
    localparam int KEY_LSB  = DATA_W - KEY_W;

    // word offsets inside the system control space
    localparam logic [ADDR_W-1:0] OFS_STATE = ADDR_W'('h341);
    localparam logic [ADDR_W-1:0] OFS_KEYED = ADDR_W'('h343);
    localparam logic [ADDR_W-1:0] OFS_PRI_A = ADDR_W'('h347);
    localparam logic [ADDR_W-1:0] OFS_PRI_B = ADDR_W'('h348);

    localparam logic [KEY_W-1:0] UNLOCK_KEY = KEY_W'('h05FA);

    // control/state word bit positions
    localparam int B_ACT_LSB  = 0;
    localparam int B_NUM_LSB  = 12;
    localparam int B_ANY_IRQ  = 22;
    localparam int B_TMR_CLR  = 25;
    localparam int B_TMR_SET  = 26;
    localparam int B_CSW_CLR  = 27;
    localparam int B_CSW_SET  = 28;
    localparam int B_NMI_SET  = 31;

    // keyed word bit positions
    localparam int B_CLR_ACT  = 1;
    localparam int B_RST_REQ  = 2;

    // priority field positions
    localparam int PRI_SVC_LSB = 30;
    localparam int PRI_CSW_LSB = 22;
    localparam int PRI_TMR_LSB = 30;

    // pendable exception slots
    localparam int P_NMI = 0;
    localparam int P_CSW = 1;
    localparam int P_TMR = 2;

    typedef struct packed {
        logic [PRIO_W-1:0] svc;
        logic [PRIO_W-1:0] csw;
        logic [PRIO_W-1:0] tmr;
    } prio_t;

    function automatic logic [EXC_W-1:0] exc_num(input int slot);
        case (slot)
            P_NMI:   return EXC_W'(2);
            P_CSW:   return EXC_W'(14);
            P_TMR:   return EXC_W'(15);
            default: return '0;
        endcase
    endfunction

    function automatic int set_pos(input int slot);
        case (slot)
            P_NMI:   return B_NMI_SET;
            P_CSW:   return B_CSW_SET;
            default: return B_TMR_SET;
        endcase
    endfunction

    // -1 marks a slot without a software clear bit
    function automatic int clr_pos(input int slot);
        case (slot)
            P_CSW:   return B_CSW_CLR;
            P_TMR:   return B_TMR_CLR;
            default: return -1;
        endcase
    endfunction
endpackage

// File: rtl/sysexc_pend_cell.sv
module sysexc_pend_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk) begin
        if (rst)        pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> pend_o);
    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !pend_o);
    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(pend_o));
endmodule

// File: rtl/sysexc_arb.sv
module sysexc_arb
    import sysexc_pkg::*;
(
    input  logic [NUM_PEND-1:0] pend_i,
    input  prio_t               prio_i,
    output logic [EXC_W-1:0]    num_o
);
    always_comb begin
        if (pend_i[P_NMI])
            num_o = exc_num(P_NMI);
        else if (pend_i[P_CSW] && pend_i[P_TMR])
            num_o = (prio_i.tmr < prio_i.csw) ? exc_num(P_TMR) : exc_num(P_CSW);
        else if (pend_i[P_CSW])
            num_o = exc_num(P_CSW);
        else if (pend_i[P_TMR])
            num_o = exc_num(P_TMR);
        else
            num_o = '0;
    end
endmodule

// File: rtl/sysexc_ctrl.sv
module sysexc_ctrl
    import sysexc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_req,
    input  logic              ack_valid,
    input  logic [EXC_W-1:0]  ack_num,
    input  logic              ext_irq_pend,
    output logic              pend_nmi,
    output logic              pend_csw,
    output logic              pend_tmr,
    output logic [EXC_W-1:0]  pend_num,
    output logic              sys_reset_req
);
    logic wr_state, wr_keyed_ok, wr_pri_a, wr_pri_b;
    logic [NUM_PEND-1:0] set_v, clr_v, pend_v;
    logic [EXC_W-1:0]    active_q;
    prio_t               prio_q;
    logic [DATA_W-1:0]   rd_word;

    assign wr_state    = bus_wr && (bus_addr == OFS_STATE);
    assign wr_keyed_ok = bus_wr && (bus_addr == OFS_KEYED) &&
                         (bus_wdata[DATA_W-1:KEY_LSB] == UNLOCK_KEY);
    assign wr_pri_a    = bus_wr && (bus_addr == OFS_PRI_A);
    assign wr_pri_b    = bus_wr && (bus_addr == OFS_PRI_B);

    // one pending cell per pendable exception
    for (genvar g = 0; g < NUM_PEND; g++) begin : g_pend
        localparam int SP = set_pos(g);
        localparam int CP = clr_pos(g);
        logic ack_hit, hw_set;

        assign ack_hit = ack_valid && (ack_num == exc_num(g));
        if (g == P_TMR) begin : g_hw
            assign hw_set = tick_req;
        end else begin : g_nohw
            assign hw_set = 1'b0;
        end

        assign set_v[g] = (wr_state && bus_wdata[SP]) || hw_set;

        if (CP >= 0) begin : g_swclr
            assign clr_v[g] = ack_hit || (wr_state && bus_wdata[CP]);
        end else begin : g_ackclr
            assign clr_v[g] = ack_hit;
        end

        sysexc_pend_cell i_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .pend_o (pend_v[g])
        );
    end

    assign pend_nmi = pend_v[P_NMI];
    assign pend_csw = pend_v[P_CSW];
    assign pend_tmr = pend_v[P_TMR];

    sysexc_arb i_arb (
        .pend_i (pend_v),
        .prio_i (prio_q),
        .num_o  (pend_num)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
        end else begin
            if (wr_pri_a)
                prio_q.svc <= bus_wdata[PRI_SVC_LSB +: PRIO_W];
            if (wr_pri_b) begin
                prio_q.csw <= bus_wdata[PRI_CSW_LSB +: PRIO_W];
                prio_q.tmr <= bus_wdata[PRI_TMR_LSB +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= '0;
        else if (wr_keyed_ok && bus_wdata[B_CLR_ACT])
            active_q <= '0;
        else if (ack_valid)
            active_q <= ack_num;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sys_reset_req <= 1'b0;
        else if (wr_keyed_ok && bus_wdata[B_RST_REQ])
            sys_reset_req <= 1'b1;
    end

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            OFS_STATE: begin
                rd_word[B_ACT_LSB +: EXC_W] = active_q;
                rd_word[B_NUM_LSB +: EXC_W] = pend_num;
                rd_word[B_ANY_IRQ]          = ext_irq_pend || pend_v[P_CSW] || pend_v[P_TMR];
                rd_word[B_TMR_SET]          = pend_v[P_TMR];
                rd_word[B_CSW_SET]          = pend_v[P_CSW];
                rd_word[B_NMI_SET]          = pend_v[P_NMI];
            end
            OFS_PRI_A: rd_word[PRI_SVC_LSB +: PRIO_W] = prio_q.svc;
            OFS_PRI_B: begin
                rd_word[PRI_CSW_LSB +: PRIO_W] = prio_q.csw;
                rd_word[PRI_TMR_LSB +: PRIO_W] = prio_q.tmr;
            end
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end

    // R5
    nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
        pend_nmi |-> (pend_num == exc_num(P_NMI)));
    // R5
    none_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v == '0) |-> (pend_num == '0));
    // R5
    num_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_num != '0) |-> (pend_v != '0));
    // R8
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_KEYED &&
         bus_wdata[DATA_W-1:KEY_LSB] != UNLOCK_KEY && !sys_reset_req) |=> !sys_reset_req);
    // R8
    rst_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |=> sys_reset_req);
    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/test_sysexc_ctrl.sv
module test_sysexc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] A_STATE = 10'h341;
    localparam logic [9:0] A_KEYED = 10'h343;
    localparam logic [9:0] A_PRI_A = 10'h347;
    localparam logic [9:0] A_PRI_B = 10'h348;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_req = 1'b0, ack_valid = 1'b0, ext_irq_pend = 1'b0;
    logic [5:0]  ack_num = '0;
    logic        pend_nmi, pend_csw, pend_tmr, sys_reset_req;
    logic [5:0]  pend_num;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysexc_ctrl i_sysexc_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_req(tick_req), .ack_valid(ack_valid), .ack_num(ack_num),
        .ext_irq_pend(ext_irq_pend), .pend_nmi(pend_nmi), .pend_csw(pend_csw),
        .pend_tmr(pend_tmr), .pend_num(pend_num), .sys_reset_req(sys_reset_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack(input logic [5:0] n);
        @(negedge clk);
        ack_valid = 1'b1; ack_num = n;
        @(negedge clk);
        ack_valid = 1'b0; ack_num = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [5:0] exp_num(input bit n, input bit c, input bit t,
                                           input int pc, input int pt);
        if (n) return 6'd2;
        if (c && t) return (pt < pc) ? 6'd15 : 6'd14;
        if (c) return 6'd14;
        if (t) return 6'd15;
        return 6'd0;
    endfunction

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] keys [4];
        keys[0] = 32'h05FB_0004; keys[1] = 32'hFA05_0004;
        keys[2] = 32'h0000_0004; keys[3] = 32'h05FA_0000;

        do_reset();
        // R1 reset state
        chk("R1 pend flags", {29'd0, pend_nmi, pend_csw, pend_tmr}, 32'd0);
        chk("R1 pend_num", {26'd0, pend_num}, 32'd0);
        chk("R1 reset req", {31'd0, sys_reset_req}, 32'd0);
        rd(A_STATE, d); chk("R1 state word", d, 32'd0);
        rd(A_PRI_A, d); chk("R1 prio A", d, 32'd0);
        rd(A_PRI_B, d); chk("R1 prio B", d, 32'd0);

        // R7 priority words, unused bits read 0
        wr(A_PRI_A, 32'hFFFF_FFFF); rd(A_PRI_A, d); chk("R7 prio A all ones", d, 32'hC000_0000);
        wr(A_PRI_B, 32'hFFFF_FFFF); rd(A_PRI_B, d); chk("R7 prio B all ones", d, 32'hC0C0_0000);
        wr(A_PRI_B, 32'h4080_0000); rd(A_PRI_B, d); chk("R7 prio B fields", d, 32'h4080_0000);
        rd(A_PRI_A, d); chk("R7 prio A kept", d, 32'hC000_0000);

        // R2 R5 R6 sweep: all pending sets x all priority pairs
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 8; m++) begin
                int  pc, pt;
                bit  en, ec, et, ex;
                logic [31:0] e;
                pc = p % 4; pt = p / 4;
                en = m[0]; ec = m[1]; et = m[2]; ex = p[0] ^ m[0];
                wr(A_STATE, 32'h0A00_0000);
                ack(6'd2);
                wr(A_PRI_B, (32'(pt) << 30) | (32'(pc) << 22));
                wr(A_STATE, {en, 2'b00, ec, 1'b0, et, 26'd0});
                ext_irq_pend = ex;
                chk("R2 pending flags", {29'd0, pend_nmi, pend_csw, pend_tmr}, {29'd0, en, ec, et});
                chk("R5 pend_num", {26'd0, pend_num}, {26'd0, exp_num(en, ec, et, pc, pt)});
                e = 32'd2 | (32'(exp_num(en, ec, et, pc, pt)) << 12) |
                    (32'(ex | ec | et) << 22) | (32'(et) << 26) |
                    (32'(ec) << 28) | (32'(en) << 31);
                rd(A_STATE, d);
                chk("R6 state word", d, e);
                ext_irq_pend = 1'b0;
            end
        end

        // R3 set/clear conflict sweep
        for (int prev = 0; prev < 2; prev++) begin
            for (int c = 0; c < 4; c++) begin
                bit s, k, e;
                s = c[1]; k = c[0];
                wr(A_STATE, prev ? 32'h1400_0000 : 32'h0A00_0000);
                wr(A_STATE, {3'b000, s, k, s, k, 25'd0});
                e = s | (prev[0] & ~k);
                chk("R3 csw set/clr", {31'd0, pend_csw}, {31'd0, e});
                chk("R3 tmr set/clr", {31'd0, pend_tmr}, {31'd0, e});
            end
        end
        // R3 tick with clear write keeps timer pending
        wr(A_STATE, 32'h0200_0000);
        @(negedge clk);
        tick_req = 1'b1; bus_wr = 1'b1; bus_addr = A_STATE; bus_wdata = 32'h0200_0000;
        @(negedge clk);
        tick_req = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        chk("R3 tick beats clear", {31'd0, pend_tmr}, 32'd1);
        wr(A_STATE, 32'h0200_0000);
        @(negedge clk); tick_req = 1'b1;
        @(negedge clk); tick_req = 1'b0;
        chk("R2 tick alone sets", {31'd0, pend_tmr}, 32'd1);

        // R4 handler-entry acknowledge
        wr(A_STATE, 32'h9400_0000);
        ack(6'd14);
        chk("R4 ack 14 clears csw", {29'd0, pend_nmi, pend_csw, pend_tmr}, 32'b101);
        rd(A_STATE, d); chk("R4 active 14", {26'd0, d[5:0]}, 32'd14);
        ack(6'd15);
        chk("R4 ack 15 clears tmr", {29'd0, pend_nmi, pend_csw, pend_tmr}, 32'b100);
        ack(6'd2);
        chk("R4 ack 2 clears nmi", {29'd0, pend_nmi, pend_csw, pend_tmr}, 32'b000);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_STATE; bus_wdata = 32'h1000_0000;
        ack_valid = 1'b1; ack_num = 6'd14;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; ack_valid = 1'b0; ack_num = '0;
        chk("R4 set beats ack", {31'd0, pend_csw}, 32'd1);
        ack(6'd0);
        rd(A_STATE, d); chk("R4 thread mode", {26'd0, d[5:0]}, 32'd0);
        wr(A_STATE, 32'h0800_0000);

        // R6 writes to read-only fields ignored
        ack(6'd15);
        wr(A_STATE, 32'h00C3_F03F);
        rd(A_STATE, d); chk("R6 read-only fields ignored", d, 32'd15);

        // R9 keyed active clear
        wr(A_KEYED, 32'h05FB_0002);
        rd(A_STATE, d); chk("R9 wrong key keeps active", {26'd0, d[5:0]}, 32'd15);
        wr(A_KEYED, 32'h05FA_0002);
        rd(A_STATE, d); chk("R9 keyed clear", {26'd0, d[5:0]}, 32'd0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_KEYED; bus_wdata = 32'h05FA_0002;
        ack_valid = 1'b1; ack_num = 6'd14;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; ack_valid = 1'b0; ack_num = '0;
        rd(A_STATE, d); chk("R9 clear beats ack", {26'd0, d[5:0]}, 32'd0);

        // R8 keyed reset request
        for (int i = 0; i < 4; i++) begin
            wr(A_KEYED, keys[i]);
            chk("R8 rejected reset write", {31'd0, sys_reset_req}, 32'd0);
        end
        wr(A_KEYED, 32'h05FA_0004);
        chk("R8 accepted reset write", {31'd0, sys_reset_req}, 32'd1);
        wr(A_KEYED, 32'h05FA_0000);
        repeat (3) @(negedge clk);
        chk("R8 request sticky", {31'd0, sys_reset_req}, 32'd1);
        rd(A_KEYED, d); chk("R8 keyed word reads 0", d, 32'd0);
        do_reset();
        chk("R1 reset clears request", {31'd0, sys_reset_req}, 32'd0);

        // R10 read port
        rd(10'h340, d); chk("R10 unmapped 0x340", d, 32'd0);
        rd(10'h344, d); chk("R10 unmapped 0x344", d, 32'd0);
        rd(10'h3FF, d); chk("R10 unmapped 0x3FF", d, 32'd0);
        wr(A_PRI_A, 32'h8000_0000);
        rd(A_PRI_A, d); chk("R10 read data", d, 32'h8000_0000);
        @(negedge clk);
        chk("R10 idle read zero", bus_rdata, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule